// File: doc/BRIEF.md
# Serial Flash Status-Register Write Engine

This block is the slave-side handler for the command that rewrites a serial flash's status and configuration registers. While chip select is low it collects bits on each rising serial clock. In single-lane mode it takes one bit per clock on data line 0. In quad mode it takes one nibble per clock on all four data lines. The opcode comes first, then one or two data bytes, most significant bit first.

When chip select rises, the engine checks the frame. The frame must carry opcode 01h and end exactly after 8 or 16 data bits. The write-enable latch must be set, hardware protection must be off, and no write may be in progress. If every check passes, the engine starts a self-timed busy period of a parameterised number of system clocks. At the end of that period the new register values take effect and the write-enable latch clears. If any check fails, the frame is dropped and nothing changes.

The serial inputs are sampled by the system clock. The serial clock must therefore run well below the system clock rate. A read-out port shows the live status byte and the configuration byte at all times.

Top module: `sfw_wrsr_engine`

## Requirements
- R1: After reset the status byte reads 00h and the configuration byte reads the CFG_RESET parameter value.
- R2: A pulse on `wel_set` while no write is in progress sets status bit 1 (write-enable latch).
- R3: An accepted frame makes status bit 0 (write in progress) read 1 for exactly BUSY_CYCLES system clocks, starting with the first clock edge that sees chip select high. After that, bit 0 and bit 1 both read 0, and status bits 7..2 equal bits 7..2 of the first data byte.
- R4: A frame with 16 data bits also loads the second data byte into the configuration register. A frame with 8 data bits leaves the configuration register unchanged.
- R5: Data bits 1..0 never reach the status register. While the write is in progress, bits 1..0 read 11b.
- R6: A frame that ends after any number of bits other than 16 or 24 in total (opcode plus data) changes nothing. It starts no busy period and leaves the write-enable latch as it was.
- R7: A frame is refused when the write-enable latch is clear.
- R8: A frame is refused while status bit 7 is 1 and `wp_n` is low. With `wp_n` high, the same frame is accepted.
- R9: A frame whose first 8 bits are not 01h is refused.
- R10: In quad mode each serial clock carries 4 bits on `sio_in[3:0]`, with bit 3 as the more significant. The high nibble of each byte comes before the low nibble.
- R11: While a write is in progress, the read-out shows the old values of bits 7..2 and of the configuration byte. A frame completed in that time is ignored, and so is a `wel_set` pulse.
- R12: Every chip-select low period starts a fresh frame. Bits left over from an earlier frame do not carry into the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, sampled by clk |
| sio_in | input | 4 | Serial data lines; only bit 0 is used in single-lane mode |
| qpi_mode | input | 1 | 1 selects nibble-per-clock transfer |
| wp_n | input | 1 | Write-protect pin, active low |
| wel_set | input | 1 | Pulse from the write-enable decoder |
| status_o | output | 8 | Live status byte: protect-disable, quad-enable, four block-protect bits, write-enable latch, write in progress |
| config_o | output | 8 | Configuration register |

## Verification
The hardest case to reach from the ports is a well-formed frame that arrives while a write is still running and the write-enable latch is still 1. In that case only the in-progress check can block it. The bench makes the busy period longer than a frame. It then sends a second valid frame and a `wel_set` pulse straight after the first commit, and confirms the second frame was still busy-blocked when it ended. Hardware protection takes a two-step setup: first a write that sets bit 7 with `wp_n` high, then a drop of `wp_n` before the next frame.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
   localparam logic [7:0] WRSR_OPCODE = 8'h01;
   localparam int         SR_HI_W     = 6;   // bits 7..2 of the status byte
   localparam int         SR_HI_SRWD  = 5;   // bit 7 within the upper field

   typedef enum logic [1:0] {
      FLEN_BAD = 2'd0,
      FLEN_ONE = 2'd1,
      FLEN_TWO = 2'd2
   } flen_e;

   typedef struct packed {
      flen_e      len;
      logic [7:0] opc;
      logic [7:0] sr;
      logic [7:0] cr;
   } frame_t;
endpackage

// File: rtl/sfw_frame_shifter.sv
module sfw_frame_shifter
   import sfw_pkg::*;
#(
   parameter bit QPI_EN = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sclk,
   input  logic [3:0] sio_in,
   input  logic       qpi_mode,
   output frame_t     frame_o,
   output logic       frame_end_o
);
   localparam int SHW     = 24;
   localparam int CNTW    = 5;
   localparam int CNT_MAX = (1 << CNTW) - 1;

   logic            cs_q, sclk_q;
   logic [SHW-1:0]  sh_q, sh_nx;
   logic [CNTW-1:0] cnt_q;
   logic [2:0]      step;
   logic [CNTW:0]   cnt_sum;
   logic            sclk_rise;

   generate
      if (QPI_EN) begin : g_quad
         always_comb begin
            if (qpi_mode) begin
               step  = 3'd4;
               sh_nx = {sh_q[SHW-5:0], sio_in};
            end else begin
               step  = 3'd1;
               sh_nx = {sh_q[SHW-2:0], sio_in[0]};
            end
         end
      end else begin : g_single
         logic unused_lanes;
         assign unused_lanes = ^{qpi_mode, sio_in[3:1]};
         assign step  = 3'd1;
         assign sh_nx = {sh_q[SHW-2:0], sio_in[0]};
      end
   endgenerate

   assign sclk_rise   = sclk & ~sclk_q & ~cs_n;
   assign frame_end_o = cs_n & ~cs_q;
   assign cnt_sum     = {1'b0, cnt_q} + (CNTW+1)'(step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
         sh_q   <= '0;
         cnt_q  <= '0;
      end else begin
         cs_q   <= cs_n;
         sclk_q <= sclk;
         if (cs_n) begin
            cnt_q <= '0;
         end else if (sclk_rise) begin
            sh_q  <= sh_nx;
            cnt_q <= (cnt_sum > (CNTW+1)'(CNT_MAX)) ? CNTW'(CNT_MAX) : cnt_sum[CNTW-1:0];
         end
      end
   end

   always_comb begin
      frame_o     = '0;
      frame_o.len = FLEN_BAD;
      if (cnt_q == CNTW'(16)) begin
         frame_o.len = FLEN_ONE;
         frame_o.opc = sh_q[15:8];
         frame_o.sr  = sh_q[7:0];
      end else if (cnt_q == CNTW'(24)) begin
         frame_o.len = FLEN_TWO;
         frame_o.opc = sh_q[23:16];
         frame_o.sr  = sh_q[15:8];
         frame_o.cr  = sh_q[7:0];
      end
   end

   // R12: a chip-select high period always leaves an empty bit count
   a_r12_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && cs_q) |-> (cnt_q == '0));
endmodule

// File: rtl/sfw_accept_gate.sv
module sfw_accept_gate
   import sfw_pkg::*;
(
   input  frame_t frame_i,
   input  logic   frame_end_i,
   input  logic   wel_i,
   input  logic   srwd_i,
   input  logic   wp_n_i,
   input  logic   busy_i,
   output logic   start_o
);
   logic len_ok, opc_ok, hw_locked;

   assign len_ok    = (frame_i.len == FLEN_ONE) || (frame_i.len == FLEN_TWO);
   assign opc_ok    = (frame_i.opc == WRSR_OPCODE);
   assign hw_locked = srwd_i & ~wp_n_i;
   assign start_o   = frame_end_i & len_ok & opc_ok & wel_i & ~hw_locked & ~busy_i;
endmodule

// File: rtl/sfw_busy_timer.sv
module sfw_busy_timer #(
   parameter int BUSY_CYCLES = 64
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = $clog2(BUSY_CYCLES + 1);

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_len
         $error("sfw_busy_timer: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign done_o = busy_o && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i) begin
         busy_o <= 1'b1;
         cnt_q  <= CW'(BUSY_CYCLES - 1);
      end else if (busy_o) begin
         if (cnt_q == '0) busy_o <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   // R3: a start reloads the full window
   a_r3_window_reload: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (busy_o && cnt_q == CW'(BUSY_CYCLES - 1)));
   // R11: no new start can land inside a running window
   a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);
endmodule

// File: rtl/sfw_wrsr_engine.sv
module sfw_wrsr_engine
   import sfw_pkg::*;
#(
   parameter int         BUSY_CYCLES = 64,
   parameter bit         QPI_EN      = 1'b1,
   parameter logic [7:0] CFG_RESET   = 8'h00
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       sclk,
   input  logic [3:0] sio_in,
   input  logic       qpi_mode,
   input  logic       wp_n,
   input  logic       wel_set,
   output logic [7:0] status_o,
   output logic [7:0] config_o
);
   frame_t             frame;
   logic               frame_end, start, busy, done;
   logic [SR_HI_W-1:0] sr_hi_q, pend_sr_q;
   logic [7:0]         cr_q, pend_cr_q;
   logic               pend_cr_en_q, wel_q;

   sfw_frame_shifter #(.QPI_EN(QPI_EN)) shifter_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
      .sio_in(sio_in), .qpi_mode(qpi_mode),
      .frame_o(frame), .frame_end_o(frame_end)
   );

   sfw_accept_gate gate_i (
      .frame_i(frame), .frame_end_i(frame_end), .wel_i(wel_q),
      .srwd_i(sr_hi_q[SR_HI_SRWD]), .wp_n_i(wp_n), .busy_i(busy),
      .start_o(start)
   );

   sfw_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) timer_i (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .busy_o(busy), .done_o(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_hi_q      <= '0;
         cr_q         <= CFG_RESET;
         pend_sr_q    <= '0;
         pend_cr_q    <= '0;
         pend_cr_en_q <= 1'b0;
         wel_q        <= 1'b0;
      end else begin
         if (start) begin
            pend_sr_q    <= frame.sr[7:2];
            pend_cr_q    <= frame.cr;
            pend_cr_en_q <= (frame.len == FLEN_TWO);
         end
         if (done) begin
            sr_hi_q <= pend_sr_q;
            if (pend_cr_en_q) cr_q <= pend_cr_q;
            wel_q   <= 1'b0;
         end else if (wel_set && !busy) begin
            wel_q   <= 1'b1;
         end
      end
   end

   assign status_o = {sr_hi_q, wel_q, busy};
   assign config_o = cr_q;

   // R7: a commit only happens with the latch set
   a_r7_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> wel_q);
   // R8: no commit under hardware protection
   a_r8_start_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !(sr_hi_q[SR_HI_SRWD] && !wp_n));
   // R5: the cycle after a commit shows both low bits set
   a_r5_busy_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (status_o[1:0] == 2'b11));
   // R3: the end of the window always leaves the latch clear
   a_r3_end_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[0]) |-> !status_o[1]);
   // R11: visible registers hold during the window
   a_r11_hold_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> ($stable(status_o[7:1]) && $stable(config_o)));
   // R6: a badly sized frame never opens a window
   a_r6_bad_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && frame.len == FLEN_BAD && !busy) |=> !busy);
endmodule

// File: tb/sfw_wrsr_engine_tb_top.sv
`timescale 1ns/1ps
module sfw_wrsr_engine_tb_top;
   localparam int BUSY = 60;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, sclk = 1'b0, qpi_mode = 1'b0, wp_n = 1'b1, wel_set = 1'b0;
   logic [3:0] sio = 4'h0;
   logic [7:0] status_o, config_o;

   int checks = 0, failures = 0;
   bit done_flag = 1'b0;

   logic [5:0] m_sr  = '0;
   logic       m_wel = 1'b0;
   logic [7:0] m_cr  = 8'h00;

   always #2.5 clk = ~clk;

   sfw_wrsr_engine #(.BUSY_CYCLES(BUSY), .QPI_EN(1'b1), .CFG_RESET(8'h00)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sio_in(sio),
      .qpi_mode(qpi_mode), .wp_n(wp_n), .wel_set(wel_set),
      .status_o(status_o), .config_o(config_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mkv(input int n, input logic [7:0] opc,
                                       input logic [7:0] s, input logic [7:0] c);
      logic [31:0] full;
      full = {8'h00, opc, s, c};
      if (n <= 24) return full >> (24 - n);
      return full << (n - 24);
   endfunction

   task automatic pulse_wel();
      wel_set = 1'b1; @(negedge clk);
      wel_set = 1'b0; @(negedge clk);
   endtask

   task automatic shift_frame(input bit q, input int n, input logic [31:0] v);
      int units;
      units = q ? n / 4 : n;
      qpi_mode = q;
      cs_n = 1'b0;
      for (int i = 0; i < units; i++) begin
         if (q) sio = v[n-1-4*i -: 4];
         else   sio = {3'b000, v[n-1-i]};
         @(negedge clk); sclk = 1'b1;
         @(negedge clk); sclk = 1'b0;
      end
      cs_n = 1'b1;
   endtask

   task automatic run_frame(input bit q, input int n, input logic [31:0] v, input string tag);
      bit         acc;
      logic [7:0] opc;
      logic [5:0] nsr;
      int         k;
      opc = (n >= 8) ? v[n-1 -: 8] : 8'h00;
      acc = (n == 16 || n == 24) && opc == 8'h01 && m_wel && !(m_sr[5] && !wp_n);
      nsr = (n == 24) ? v[15:10] : v[7:2];
      shift_frame(q, n, v);
      @(negedge clk);
      if (acc) begin
         check(status_o[1:0] == 2'b11 && status_o[7:2] == m_sr && config_o == m_cr,
               "R11", "old values with WIP/WEL during write",
               {16'h0, status_o, config_o}, {16'h0, m_sr, 2'b11, m_cr});
      end
      k = 0;
      while (status_o[0] && k < 1000) begin k++; @(negedge clk); end
      check(k == (acc ? BUSY : 0), tag, "busy clocks", k, acc ? BUSY : 0);
      if (acc) begin
         m_sr  = nsr;
         m_wel = 1'b0;
         if (n == 24) m_cr = v[7:0];
      end
      check(status_o == {m_sr, m_wel, 1'b0}, tag, "status after frame", status_o, {m_sr, m_wel, 1'b0});
      check(config_o == m_cr, tag, "config after frame", config_o, m_cr);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      check(status_o == 8'h00, "R1", "status reset", status_o, 8'h00);
      check(config_o == 8'h00, "R1", "config reset", config_o, 8'h00);

      // R7: no latch, frame refused
      run_frame(1'b0, 16, mkv(16, 8'h01, 8'hFC, 8'h00), "R7");

      // R2: latch set
      pulse_wel(); m_wel = 1'b1;
      check(status_o[1] == 1'b1, "R2", "latch set", status_o[1], 1);

      // R9: wrong opcodes refused, latch kept
      run_frame(1'b0, 16, mkv(16, 8'h02, 8'hFC, 8'h00), "R9");
      run_frame(1'b0, 16, mkv(16, 8'h81, 8'hFC, 8'h00), "R9");
      run_frame(1'b1, 24, mkv(24, 8'h00, 8'hFC, 8'h55), "R9");

      // R6, R12: every wrong bit count in single-lane mode, then quad
      for (int n = 1; n <= 28; n++)
         if (n != 16 && n != 24) run_frame(1'b0, n, mkv(n, 8'h01, 8'hA7, 8'h3C), "R6");
      for (int n = 4; n <= 28; n += 4)
         if (n != 16 && n != 24) run_frame(1'b1, n, mkv(n, 8'h01, 8'h5B, 8'hC3), "R6");

      // R3, R5: one-byte sweep of every status value
      for (int d = 0; d < 256; d++) begin
         pulse_wel(); m_wel = 1'b1;
         run_frame(1'b0, 16, mkv(16, 8'h01, 8'(d), 8'hEE), "R3");
      end

      // R4, R10: two-byte quad sweep
      for (int d = 0; d < 64; d++) begin
         pulse_wel(); m_wel = 1'b1;
         run_frame(1'b1, 24, mkv(24, 8'h01, 8'(d * 4 + 3), 8'(~(d * 5))), "R10");
      end
      // R4: two-byte single-lane, then one-byte keeps config
      pulse_wel(); m_wel = 1'b1;
      run_frame(1'b0, 24, mkv(24, 8'h01, 8'h40, 8'h96), "R4");
      pulse_wel(); m_wel = 1'b1;
      run_frame(1'b0, 16, mkv(16, 8'h01, 8'h24, 8'h00), "R4");

      // R8: set protect-disable, then pull wp_n low
      pulse_wel(); m_wel = 1'b1;
      run_frame(1'b0, 16, mkv(16, 8'h01, 8'h88, 8'h00), "R8");
      wp_n = 1'b0;
      pulse_wel(); m_wel = 1'b1;
      run_frame(1'b0, 16, mkv(16, 8'h01, 8'h00, 8'h00), "R8");
      check(status_o[1] == 1'b1, "R8", "latch kept when locked", status_o[1], 1);
      wp_n = 1'b1;
      run_frame(1'b0, 16, mkv(16, 8'h01, 8'h00, 8'h00), "R8");

      // R11: frame and latch pulse inside a running write
      pulse_wel(); m_wel = 1'b1;
      shift_frame(1'b0, 16, mkv(16, 8'h01, 8'h3C, 8'h00));
      @(negedge clk);
      pulse_wel();
      shift_frame(1'b0, 16, mkv(16, 8'h01, 8'hFC, 8'h00));
      @(negedge clk);
      check(status_o[1:0] == 2'b11, "R11", "second frame ended inside write", status_o[1:0], 3);
      k = 0;
      while (status_o[0] && k < 1000) begin k++; @(negedge clk); end
      m_sr = 6'h0F; m_wel = 1'b0;
      check(status_o == 8'h3C, "R11", "overlapping frame ignored", status_o, 8'h3C);
      check(config_o == m_cr, "R11", "config held", config_o, m_cr);

      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule